// File: doc/BRIEF.md
# Equalization Evaluation Timeout Controller

This block paces receiver-equalization evaluation while a link sits in its active equalization phase. A start request from the coefficient-selection logic raises an evaluation request and an in-progress flag toward a PIPE-like PHY. A programmable per-setting timer then bounds how long that one transmitter setting may be evaluated. Timing uses a 16 ns tick, and the bench runs with one tick per clock.

A second timer bounds the whole phase. When it expires, the block pulses a request to leave for the speed-change recovery state and removes the evaluation request in that same cycle. If an evaluation was still outstanding at that moment, the in-progress flag stays high until the PHY answers with a status pulse. A selectable abort timer caps that wait. If no evaluation was outstanding, the flag is released at once. A control bit can detach the in-progress flag entirely, so it can never hang on a PHY whose clock has stopped.

The control fields live in one 32-bit word that is written and read through a plain write strobe and a read bus.

Top module: `eq_eval_timer`

## Requirements
- R1: Control word layout: bits [31:4] hold the per-setting limit in ticks, bit 3 is reserved, bit 2 is the decouple bit, and bits [1:0] hold the abort mode. Reset value: limit 125000 (300 when the short-simulation parameter is set), decouple 0, mode 3. Bit 3 always reads 0 and ignores writes.
- R2: A start request is accepted only while phase_active is high and no abort is pending. An accepted start makes rx_eq_eval and rx_eq_in_progress high from the next cycle. A start request while phase_active is low changes neither output.
- R3: Once started, rx_eq_eval stays high for exactly `limit` ticks. setting_timeout pulses for one cycle in the last of those ticks, and rx_eq_eval is low in the following cycle. A new start request reloads the count.
- R4: A phy_status pulse outside an abort clears rx_eq_eval and rx_eq_in_progress in the next cycle.
- R5: abort_req is a one-cycle pulse in the PHASE_TICKS-th consecutive tick of phase_active. The phase count restarts from zero whenever phase_active falls.
- R6: In the cycle abort_req is high, rx_eq_eval is low, even if an evaluation was running.
- R7: If rx_eq_eval was asserted when the abort fired, rx_eq_in_progress stays high after the abort until a phy_status pulse arrives, and drops in the cycle after that pulse.
- R8: The abort mode caps that wait. Mode 0 allows ABORT_TICKS_0 ticks (1 us by default), mode 1 allows ABORT_TICKS_1 (10 us), mode 2 allows ABORT_TICKS_2 (100 us) and mode 3 allows ABORT_TICKS_3 (1 ms). If no status arrives, rx_eq_in_progress is low in the cycle after that many ticks of waiting.
- R9: If rx_eq_eval was not asserted when the abort fired, rx_eq_in_progress is low in the next cycle.
- R10: After an abort, start requests are ignored until phase_active falls.
- R11: While the decouple bit is set, rx_eq_in_progress stays low whatever the evaluation state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_active | input | 1 | High while the link is in the active equalization phase |
| eval_start | input | 1 | Request to start evaluating a new transmitter setting |
| phy_status | input | 1 | Status pulse from the PHY |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| rx_eq_eval | output | 1 | Evaluation request to the PHY |
| rx_eq_in_progress | output | 1 | Equalization in-progress flag to the PHY |
| setting_timeout | output | 1 | One-cycle pulse when the per-setting limit expires |
| abort_req | output | 1 | One-cycle request to leave for speed-change recovery |

## Verification
The bench targets the cycle on which each timer fires. An off-by-one in the per-setting or phase count would move setting_timeout or abort_req by one cycle. A registered rather than immediate drop of rx_eq_eval on abort would leave the request high in the abort cycle.

The abort itself is exercised with an evaluation running and with one finished. A design that always waited would hang the in-progress flag when the evaluation had already ended. A design that never waited would release the flag before the PHY answered.

All four abort-timer modes are run, plus an early status pulse. A mis-decoded mode shows up as a release on the wrong cycle. The bench also drops phase_active part-way through a phase, which exposes a phase counter that does not clear. It checks that start requests after an abort and with the phase inactive are ignored, and that the decouple bit and the reserved bit behave as required.

// File: rtl/eqt_pkg.sv
package eqt_pkg;

  localparam int CFG_W   = 32;
  localparam int LIMIT_W = 28;

  localparam logic [LIMIT_W-1:0] LIMIT_RST_FULL  = 28'd125000;
  localparam logic [LIMIT_W-1:0] LIMIT_RST_SHORT = 28'd300;

  typedef enum logic [1:0] {
    ABT_1US   = 2'd0,
    ABT_10US  = 2'd1,
    ABT_100US = 2'd2,
    ABT_1MS   = 2'd3
  } abort_mode_e;

  typedef struct packed {
    logic [LIMIT_W-1:0] eval_limit;
    logic               rsvd;
    logic               decouple;
    abort_mode_e        mode;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(logic [CFG_W-1:0] w);
    ctrl_t c;
    c      = ctrl_t'(w);
    c.rsvd = 1'b0;
    return c;
  endfunction

  function automatic logic [31:0] abort_ticks(abort_mode_e m, logic [31:0] t0,
                                              logic [31:0] t1, logic [31:0] t2,
                                              logic [31:0] t3);
    case (m)
      ABT_1US:   return t0;
      ABT_10US:  return t1;
      ABT_100US: return t2;
      default:   return t3;
    endcase
  endfunction

endpackage

// File: rtl/eqt_ctrl_reg.sv
module eqt_ctrl_reg #(
  parameter bit SHORT_SIM = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [eqt_pkg::CFG_W-1:0]    wdata,
  output eqt_pkg::ctrl_t               ctrl
);
  import eqt_pkg::*;

  localparam logic [LIMIT_W-1:0] LIMIT_RST = SHORT_SIM ? LIMIT_RST_SHORT : LIMIT_RST_FULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.eval_limit <= LIMIT_RST;
      ctrl.rsvd       <= 1'b0;
      ctrl.decouple   <= 1'b0;
      ctrl.mode       <= ABT_1MS;
    end else if (wr_en) begin
      ctrl <= ctrl_from_word(wdata);
    end
  end

endmodule

// File: rtl/eqt_tick_gen.sv
module eqt_tick_gen #(
  parameter int TICK_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_CYCLES <= 1) begin : g_every_clock
      assign tick = 1'b1;
    end else begin : g_divided
      localparam int TW = $clog2(TICK_CYCLES);
      localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);
      logic [TW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/eqt_timer.sv
module eqt_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         hit
);
  logic [W:0] next_ext;

  always_comb next_ext = {1'b0, count} + (W+1)'(1);

  // Fires on the tick that completes `limit` counted ticks (limit 0 acts as 1).
  assign hit = run & ~clear & (next_ext >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (clear)                count <= '0;
    else if (run && (~count != '0)) count <= count + 1'b1;
  end

endmodule

// File: rtl/eq_eval_timer.sv
module eq_eval_timer #(
  parameter int TICK_CYCLES   = 1,
  parameter bit SHORT_SIM     = 1'b0,
  parameter int PHASE_TICKS   = 1500000,
  parameter int ABORT_TICKS_0 = 63,
  parameter int ABORT_TICKS_1 = 625,
  parameter int ABORT_TICKS_2 = 6250,
  parameter int ABORT_TICKS_3 = 62500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        phase_active,
  input  logic        eval_start,
  input  logic        phy_status,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        rx_eq_eval,
  output logic        rx_eq_in_progress,
  output logic        setting_timeout,
  output logic        abort_req
);
  import eqt_pkg::*;

  localparam int PW = $clog2(PHASE_TICKS + 1);
  localparam int AW = $clog2(ABORT_TICKS_3 + 1);   // mode 3 is the longest wait
  localparam logic [PW-1:0] PHASE_LIM = PW'(PHASE_TICKS);

  ctrl_t ctrl;
  logic  tick;

  logic  eval_q, inprog_q, aborted_q, waiting_q;
  abort_mode_e mode_q;

  logic  start_acc, phase_expire;
  logic  set_clr, set_run, set_hit;
  logic  phase_clr, phase_run, phase_hit;
  logic  abort_clr, abort_run, abort_hit;
  logic  decouple;

  logic [LIMIT_W-1:0] set_cnt;
  logic [PW-1:0]      phase_cnt;
  logic [AW-1:0]      abort_cnt;
  logic [31:0]        abort_lim_full;
  logic [AW-1:0]      abort_lim;

  eqt_ctrl_reg #(.SHORT_SIM(SHORT_SIM)) i_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .wdata (cfg_wdata),
    .ctrl  (ctrl)
  );

  eqt_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) i_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  // Named events
  assign decouple     = ctrl.decouple;
  assign start_acc    = eval_start & phase_active & ~aborted_q & ~waiting_q;
  assign phase_run    = phase_active & tick & ~aborted_q;
  assign phase_clr    = ~phase_active | aborted_q;
  assign phase_expire = phase_hit;
  assign set_run      = eval_q & tick;
  assign set_clr      = ~eval_q | start_acc;
  assign abort_run    = waiting_q & tick;
  assign abort_clr    = ~waiting_q;

  always_comb begin
    abort_lim_full = abort_ticks(mode_q, 32'(ABORT_TICKS_0), 32'(ABORT_TICKS_1),
                                 32'(ABORT_TICKS_2), 32'(ABORT_TICKS_3));
    abort_lim      = abort_lim_full[AW-1:0];
  end

  eqt_timer #(.W(LIMIT_W)) i_set_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (set_clr),
    .run   (set_run),
    .limit (ctrl.eval_limit),
    .count (set_cnt),
    .hit   (set_hit)
  );

  eqt_timer #(.W(PW)) i_phase_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (phase_clr),
    .run   (phase_run),
    .limit (PHASE_LIM),
    .count (phase_cnt),
    .hit   (phase_hit)
  );

  eqt_timer #(.W(AW)) i_abort_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (abort_clr),
    .run   (abort_run),
    .limit (abort_lim),
    .count (abort_cnt),
    .hit   (abort_hit)
  );

  // Outputs
  assign setting_timeout   = set_hit & ~phase_expire;
  assign abort_req         = phase_expire;
  assign rx_eq_eval        = eval_q & ~phase_expire;
  assign rx_eq_in_progress = inprog_q & ~decouple;
  assign cfg_rdata         = ctrl;

  // Evaluation request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             eval_q <= 1'b0;
    else if (phase_expire)                  eval_q <= 1'b0;
    else if (start_acc)                     eval_q <= 1'b1;
    else if (setting_timeout || phy_status) eval_q <= 1'b0;
  end

  // Abort bookkeeping within the phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aborted_q <= 1'b0;
      mode_q    <= ABT_1MS;
    end else if (phase_expire) begin
      aborted_q <= 1'b1;
      mode_q    <= ctrl.mode;
    end else if (!phase_active) begin
      aborted_q <= 1'b0;
    end
  end

  // In-progress flag and bounded wait for PHY status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inprog_q  <= 1'b0;
      waiting_q <= 1'b0;
    end else if (phase_expire) begin
      inprog_q  <= eval_q;
      waiting_q <= eval_q;
    end else if (waiting_q) begin
      if (phy_status || abort_hit) begin
        inprog_q  <= 1'b0;
        waiting_q <= 1'b0;
      end
    end else if (start_acc) begin
      inprog_q <= 1'b1;
    end else if (phy_status) begin
      inprog_q <= 1'b0;
    end
  end

  logic unused_cnt;
  assign unused_cnt = ^{set_cnt, phase_cnt, abort_cnt, abort_lim_full};

endmodule

// File: rtl/eqt_checker.sv
module eqt_checker (
  input logic clk,
  input logic rst_n,
  input logic abort_req,
  input logic setting_timeout,
  input logic rx_eq_eval,
  input logic rx_eq_in_progress,
  input logic decouple,
  input logic eval_q,
  input logic inprog_q,
  input logic aborted_q,
  input logic waiting_q,
  input logic abort_hit
);

  AST_EVAL_LOW_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> !rx_eq_eval); // R6

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req); // R5

  AST_TIMEOUT_DROPS_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    setting_timeout |=> !rx_eq_eval); // R3

  AST_NO_EVAL_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    aborted_q |-> !rx_eq_eval); // R10

  AST_EVAL_HAS_INPROG: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eq_eval && !decouple) |-> rx_eq_in_progress); // R2

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req && !eval_q) |=> !inprog_q); // R9

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_q && abort_hit) |=> !inprog_q); // R8

endmodule

bind eq_eval_timer eqt_checker i_eqt_checker (
  .clk               (clk),
  .rst_n             (rst_n),
  .abort_req         (abort_req),
  .setting_timeout   (setting_timeout),
  .rx_eq_eval        (rx_eq_eval),
  .rx_eq_in_progress (rx_eq_in_progress),
  .decouple          (decouple),
  .eval_q            (eval_q),
  .inprog_q          (inprog_q),
  .aborted_q         (aborted_q),
  .waiting_q         (waiting_q),
  .abort_hit         (abort_hit)
);

// File: tb/test_eq_eval_timer.sv
module test_eq_eval_timer;

  localparam int P  = 40;
  localparam int A0 = 5;
  localparam int A1 = 8;
  localparam int A2 = 12;
  localparam int A3 = 20;
  localparam int L  = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        rst_n, phase_active, eval_start, phy_status, cfg_wr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        rx_eq_eval, rx_eq_in_progress, setting_timeout, abort_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  eq_eval_timer #(
    .TICK_CYCLES(1), .SHORT_SIM(1'b0), .PHASE_TICKS(P),
    .ABORT_TICKS_0(A0), .ABORT_TICKS_1(A1), .ABORT_TICKS_2(A2), .ABORT_TICKS_3(A3)
  ) i_eq_eval_timer (
    .clk(clk), .rst_n(rst_n), .phase_active(phase_active), .eval_start(eval_start),
    .phy_status(phy_status), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rx_eq_eval(rx_eq_eval), .rx_eq_in_progress(rx_eq_in_progress),
    .setting_timeout(setting_timeout), .abort_req(abort_req)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic cfg(logic [27:0] lim, logic dec, logic [1:0] mode, logic rsv = 1'b0);
    cfg_wdata = {lim, rsv, dec, mode};
    cfg_wr = 1'b1;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic idle();
    phase_active = 1'b0; eval_start = 1'b0; phy_status = 1'b0;
    step(2);
  endtask

  task automatic test_reset();
    chk("R1", "reset word", cfg_rdata, {28'd125000, 1'b0, 1'b0, 2'd3});
    chk("R2", "reset eval", rx_eq_eval, 0);
    chk("R2", "reset inprog", rx_eq_in_progress, 0);
    chk("R5", "reset abort", abort_req, 0);
  endtask

  task automatic test_reg();
    cfg(28'd1000, 1'b0, 2'd1, 1'b1);
    chk("R1", "reserved bit ignored", cfg_rdata, {28'd1000, 1'b0, 1'b0, 2'd1});
  endtask

  task automatic test_start_ignored();
    eval_start = 1'b1; step(); eval_start = 1'b0;
    chk("R2", "start w/o phase eval", rx_eq_eval, 0);
    chk("R2", "start w/o phase inprog", rx_eq_in_progress, 0);
  endtask

  task automatic test_setting();
    cfg(28'(L), 1'b0, 2'd3);
    phase_active = 1'b1; eval_start = 1'b1; step(); eval_start = 1'b0;
    chk("R2", "eval after start", rx_eq_eval, 1);
    chk("R2", "inprog after start", rx_eq_in_progress, 1);
    step(L - 2);
    chk("R3", "no early timeout", setting_timeout, 0);
    step();
    chk("R3", "timeout pulse", setting_timeout, 1);
    chk("R3", "eval in last tick", rx_eq_eval, 1);
    step();
    chk("R3", "eval dropped", rx_eq_eval, 0);
    chk("R3", "pulse one cycle", setting_timeout, 0);
    chk("R4", "inprog waits status", rx_eq_in_progress, 1);
    phy_status = 1'b1; step(); phy_status = 1'b0;
    chk("R4", "inprog cleared", rx_eq_in_progress, 0);
    idle();
    // restart reloads the count
    phase_active = 1'b1; eval_start = 1'b1; step(); eval_start = 1'b0;
    step(3);
    eval_start = 1'b1; step(); eval_start = 1'b0;
    step(L - 2);
    chk("R3", "reload no timeout", setting_timeout, 0);
    chk("R3", "reload eval held", rx_eq_eval, 1);
    step();
    chk("R3", "reload timeout", setting_timeout, 1);
    idle();
    // status ends a running evaluation
    phase_active = 1'b1; eval_start = 1'b1; step(); eval_start = 1'b0;
    phy_status = 1'b1; step(); phy_status = 1'b0;
    chk("R4", "status clears eval", rx_eq_eval, 0);
    chk("R4", "status clears inprog", rx_eq_in_progress, 0);
    idle();
  endtask

  task automatic test_abort(logic [1:0] mode, int a, bit early, bit pre_phase);
    cfg(28'd1000, 1'b0, mode);
    if (pre_phase) begin
      phase_active = 1'b1; step(10); phase_active = 1'b0; step();
    end
    phase_active = 1'b1; eval_start = 1'b1; step(); eval_start = 1'b0;
    step(P - 3);
    chk("R5", "no early abort", abort_req, 0);
    chk("R6", "eval before abort", rx_eq_eval, 1);
    step();
    chk("R5", "abort pulse", abort_req, 1);
    chk("R6", "eval low on abort", rx_eq_eval, 0);
    step();
    chk("R5", "abort one cycle", abort_req, 0);
    chk("R7", "inprog held", rx_eq_in_progress, 1);
    if (early) begin
      step();
      chk("R7", "inprog before status", rx_eq_in_progress, 1);
      phy_status = 1'b1; step(); phy_status = 1'b0;
      chk("R7", "inprog after status", rx_eq_in_progress, 0);
    end else begin
      step(a - 1);
      chk("R8", "inprog before limit", rx_eq_in_progress, 1);
      step();
      chk("R8", "inprog after limit", rx_eq_in_progress, 0);
    end
    eval_start = 1'b1; step(); eval_start = 1'b0;
    chk("R10", "start after abort eval", rx_eq_eval, 0);
    chk("R10", "start after abort inprog", rx_eq_in_progress, 0);
    idle();
  endtask

  task automatic test_idle_abort();
    cfg(28'(L), 1'b0, 2'd3);
    phase_active = 1'b1; eval_start = 1'b1; step(); eval_start = 1'b0;
    step(L);
    chk("R9", "eval ended", rx_eq_eval, 0);
    chk("R9", "inprog pending", rx_eq_in_progress, 1);
    step(P - L - 2);
    chk("R9", "abort pulse", abort_req, 1);
    step();
    chk("R9", "inprog released", rx_eq_in_progress, 0);
    idle();
  endtask

  task automatic test_decouple();
    cfg(28'd1000, 1'b1, 2'd3);
    phase_active = 1'b1; eval_start = 1'b1; step(); eval_start = 1'b0;
    chk("R11", "eval runs", rx_eq_eval, 1);
    chk("R11", "inprog decoupled", rx_eq_in_progress, 0);
    phy_status = 1'b1; step(); phy_status = 1'b0;
    idle();
    cfg(28'd1000, 1'b0, 2'd3);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    rst_n = 1'b0; phase_active = 1'b0; eval_start = 1'b0; phy_status = 1'b0;
    cfg_wr = 1'b0; cfg_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step();
    test_reset();
    test_reg();
    test_start_ignored();
    test_setting();
    test_abort(2'd0, A0, 1'b0, 1'b1);
    test_abort(2'd1, A1, 1'b1, 1'b0);
    test_abort(2'd2, A2, 1'b0, 1'b0);
    test_abort(2'd3, A3, 1'b0, 1'b0);
    test_idle_abort();
    test_decouple();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule